// File: doc/BRIEF.md
# Predicated Execute Unit with Condition Flags

This execute-stage block runs a small predicated instruction subset on 32-bit data held in a 16-entry register file outside the block. A compare subtracts two register operands only to record condition flags: equal, not-equal, signed less-than and signed greater-than. Add and subtract operations carry a 4-bit condition field. They write their result only when the stored flags satisfy that condition. A branch operation is resolved from the same flags. Because a compare can steer later writes directly, a short data-dependent loop such as a subtract-until-equal reduction needs one branch per iteration instead of one per decision.

The add path shifts its second operand left by a 5-bit immediate before the sum is formed. This turns scaled-index and multiply-by-power-of-two arithmetic into a single operation. Each decoded operation is applied for one cycle. The two source indices go straight out as read addresses. The write port (enable, index, data) and the branch-taken flag are registered and appear one clock edge later. The registered write is forwarded back to the operands, so a dependent operation can follow in the very next cycle.

Opcodes (3 bits): 0 no-op, 1 compare, 2 shifted add, 3 subtract, 4 branch. Condition codes (4 bits): 0 always, 1 equal, 2 not equal, 3 less than, 4 greater than, 5 less or equal, 6 greater or equal, 7 to 15 never.

Top module: `pe_exec_unit`

## Requirements
- R1: After reset, rf_we_o and br_taken_o are 0 and all flags are clear, so only condition code 0 (always) lets an operation act.
- R2: A compare (opcode 1) never writes a register. It ignores its condition field and always sets the flags from signed two's-complement rs vs rt: equal, not-equal, less-than, greater-than.
- R3: A subtract (opcode 3, rd = rs - rt modulo 2^32) with condition 4 (greater than) writes only when the last compare found rs > rt.
- R4: A subtract with condition 5 (less or equal) writes only when the last compare found rs <= rt.
- R5: A branch (opcode 4) with condition 2 (not equal) sets br_taken_o only when the last compare found the operands unequal. A branch never writes a register.
- R6: A shifted add (opcode 2) writes rd = rs + (rt << shamt) modulo 2^32, with shamt 0 to 31 and bits shifted past bit 31 dropped.
- R7: Condition 0 always executes. Conditions 1, 2, 3 and 6 follow the equal, not-equal, less-than and greater-or-equal flags. Codes 7 to 15 never execute.
- R8: The flags change only on a compare. Add, subtract, branch, no-op, suppressed operations and idle cycles leave them unchanged.
- R9: Every operation, executed or suppressed, takes one cycle. Its write or branch result appears after the next rising clock edge, and a suppressed operation leaves rf_we_o low.
- R10: An operation that reads a register written by the operation in the previous cycle uses the newly written value.
- R11: With op_valid_i low, no write and no branch take place, and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Decoded operation present this cycle |
| op_code_i | input | 3 | Opcode |
| cond_i | input | 4 | Condition code |
| rd_i | input | 4 | Destination register index |
| rs_i | input | 4 | First source register index |
| rt_i | input | 4 | Second source register index |
| shamt_i | input | 5 | Left shift of the second operand on add |
| rf_ra_o | output | 4 | Register file read address A (rs) |
| rf_rb_o | output | 4 | Register file read address B (rt) |
| rf_a_i | input | 32 | Register file read data A |
| rf_b_i | input | 32 | Register file read data B |
| rf_we_o | output | 1 | Register file write enable |
| rf_wa_o | output | 4 | Register file write index |
| rf_wd_o | output | 32 | Register file write data |
| br_taken_o | output | 1 | Branch taken |

## Verification
Each write or branch result is due one rising edge after its operation is applied. Compare flags are stored at that same edge and steer the operation applied next. The bench applies operations on the falling edge and samples the write port and branch flag on the following falling edge, so every check lands exactly one edge after its stimulus. Operations are issued back to back, which makes every dependent read rely on the forwarding path. The bench's own register model, written from the write port, is compared with the architectural model at the end.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_CMP = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_BR  = 3'd4
  } pe_op_e;

  typedef enum logic [3:0] {
    C_AL = 4'd0,
    C_EQ = 4'd1,
    C_NE = 4'd2,
    C_LT = 4'd3,
    C_GT = 4'd4,
    C_LE = 4'd5,
    C_GE = 4'd6
  } pe_cond_e;

  typedef struct packed {
    logic gt;
    logic lt;
    logic ne;
    logic eq;
  } pe_flags_t;
endpackage

// File: rtl/pe_shifter.sv
module pe_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] stg [SHW+1];

  assign stg[0] = data_i;

  // logarithmic left shifter, one stage per amount bit
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    assign stg[i+1] = amt_i[i] ? (stg[i] << (1 << i)) : stg[i];
  end

  assign data_o = stg[SHW];
endmodule

// File: rtl/pe_alu.sv
module pe_alu import pe_pkg::*; #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] sum_o,
  output logic [XLEN-1:0] diff_o,
  output pe_flags_t       cmp_o
);
  logic [XLEN-1:0] b_sh;

  pe_shifter #(.XLEN(XLEN)) i_shifter (
    .data_i (b_i),
    .amt_i  (shamt_i),
    .data_o (b_sh)
  );

  assign sum_o  = a_i + b_sh;
  assign diff_o = a_i - b_i;

  always_comb begin
    cmp_o.eq = (diff_o == '0);
    cmp_o.ne = (diff_o != '0);
    cmp_o.lt = ($signed(a_i) < $signed(b_i));
    cmp_o.gt = !cmp_o.eq && !cmp_o.lt;
  end
endmodule

// File: rtl/pe_cond_eval.sv
module pe_cond_eval import pe_pkg::*; (
  input  logic [3:0] cond_i,
  input  pe_flags_t  flags_i,
  output logic       pass_o
);
  always_comb begin
    unique case (cond_i)
      C_AL:    pass_o = 1'b1;
      C_EQ:    pass_o = flags_i.eq;
      C_NE:    pass_o = flags_i.ne;
      C_LT:    pass_o = flags_i.lt;
      C_GT:    pass_o = flags_i.gt;
      C_LE:    pass_o = flags_i.lt | flags_i.eq;
      C_GE:    pass_o = flags_i.gt | flags_i.eq;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pe_flag_reg.sv
module pe_flag_reg import pe_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      upd_i,
  input  pe_flags_t nxt_i,
  output pe_flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= nxt_i;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(q_o)); // R8

  AST_FLAGS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> ($countones({q_o.eq, q_o.lt, q_o.gt}) == 1) && (q_o.ne != q_o.eq)); // R2
endmodule

// File: rtl/pe_exec_unit.sv
module pe_exec_unit import pe_pkg::*; #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RAW = $clog2(NREG),
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [2:0]      op_code_i,
  input  logic [3:0]      cond_i,
  input  logic [RAW-1:0]  rd_i,
  input  logic [RAW-1:0]  rs_i,
  input  logic [RAW-1:0]  rt_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [RAW-1:0]  rf_ra_o,
  output logic [RAW-1:0]  rf_rb_o,
  input  logic [XLEN-1:0] rf_a_i,
  input  logic [XLEN-1:0] rf_b_i,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_wa_o,
  output logic [XLEN-1:0] rf_wd_o,
  output logic            br_taken_o
);
  pe_op_e          op;
  logic [XLEN-1:0] opa, opb, sum, diff;
  pe_flags_t       cmp_flags, flags_q;
  logic            pass, is_cmp, is_arith, we_d, br_d;

  assign op       = pe_op_e'(op_code_i);
  assign rf_ra_o  = rs_i;
  assign rf_rb_o  = rt_i;

  // forward the registered write to a dependent operation
  assign opa = (rf_we_o && rf_wa_o == rs_i) ? rf_wd_o : rf_a_i;
  assign opb = (rf_we_o && rf_wa_o == rt_i) ? rf_wd_o : rf_b_i;

  pe_alu #(.XLEN(XLEN)) i_alu (
    .a_i     (opa),
    .b_i     (opb),
    .shamt_i (shamt_i),
    .sum_o   (sum),
    .diff_o  (diff),
    .cmp_o   (cmp_flags)
  );

  pe_cond_eval i_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (pass)
  );

  assign is_cmp   = op_valid_i && (op == OP_CMP);
  assign is_arith = op_valid_i && (op == OP_ADD || op == OP_SUB);
  assign we_d     = is_arith && pass;
  assign br_d     = op_valid_i && (op == OP_BR) && pass;

  pe_flag_reg i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (is_cmp),
    .nxt_i  (cmp_flags),
    .q_o    (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_we_o    <= 1'b0;
      rf_wa_o    <= '0;
      rf_wd_o    <= '0;
      br_taken_o <= 1'b0;
    end else begin
      rf_we_o    <= we_d;
      rf_wa_o    <= rd_i;
      rf_wd_o    <= (op == OP_ADD) ? sum : diff;
      br_taken_o <= br_d;
    end
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 3'd1) |=> !rf_we_o); // R2

  AST_BR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_o |-> !rf_we_o); // R5

  AST_ALWAYS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_code_i == 3'd2 || op_code_i == 3'd3) && cond_i == 4'd0)
      |=> rf_we_o && rf_wa_o == $past(rd_i)); // R7

  AST_NEVER_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i >= 4'd7) |=> !rf_we_o && !br_taken_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !rf_we_o && !br_taken_o); // R11
endmodule

// File: tb/test_pe_exec_unit.sv
`timescale 1ns/1ps
module test_pe_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [3:0]  cond;
  logic [3:0]  rd, rs, rt;
  logic [4:0]  shamt;
  logic [3:0]  ra, rb;
  logic [31:0] a_dat, b_dat;
  logic        we;
  logic [3:0]  wa;
  logic [31:0] wd;
  logic        br;

  logic [31:0] rf   [16];
  logic [31:0] arch [16];
  logic f_eq, f_lt, f_gt;
  logic last_br;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pe_exec_unit i_pe_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .cond_i(cond), .rd_i(rd), .rs_i(rs), .rt_i(rt), .shamt_i(shamt),
    .rf_ra_o(ra), .rf_rb_o(rb), .rf_a_i(a_dat), .rf_b_i(b_dat),
    .rf_we_o(we), .rf_wa_o(wa), .rf_wd_o(wd), .br_taken_o(br)
  );

  assign a_dat = rf[ra];
  assign b_dat = rf[rb];

  always @(posedge clk) if (rst_n && we) rf[wa] <= wd;

  function automatic logic cond_ok(input logic [3:0] c);
    case (c)
      4'd0: return 1'b1;
      4'd1: return f_eq;
      4'd2: return !f_eq && (f_lt || f_gt);
      4'd3: return f_lt;
      4'd4: return f_gt;
      4'd5: return f_lt || f_eq;
      4'd6: return f_gt || f_eq;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic issue(input string req, input logic v, input logic [2:0] o,
                       input logic [3:0] c, input logic [3:0] d, input logic [3:0] s,
                       input logic [3:0] t, input logic [4:0] sh);
    logic e_we, e_br;
    logic [31:0] e_wd;
    logic [31:0] x, y;
    e_we = 1'b0; e_br = 1'b0; e_wd = '0;
    x = arch[s]; y = arch[t];
    op_valid = v; op_code = o; cond = c; rd = d; rs = s; rt = t; shamt = sh;
    if (v) begin
      case (o)
        3'd1: begin
          f_eq = (x == y);
          f_lt = ($signed(x) < $signed(y));
          f_gt = ($signed(x) > $signed(y));
        end
        3'd2: if (cond_ok(c)) begin e_we = 1'b1; e_wd = x + (y << sh); end
        3'd3: if (cond_ok(c)) begin e_we = 1'b1; e_wd = x - y; end
        3'd4: e_br = cond_ok(c);
        default: ;
      endcase
    end
    if (e_we) arch[d] = e_wd;
    @(negedge clk);
    last_br = br;
    check(req, {we, br, (we ? wa : 4'd0), (we ? wd : 32'd0)},
               {e_we, e_br, (e_we ? d : 4'd0), e_wd});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int iter;
    void'($urandom(32'd1234));
    rst_n = 1'b0; op_valid = 0; op_code = 0; cond = 0; rd = 0; rs = 0; rt = 0; shamt = 0;
    f_eq = 0; f_lt = 0; f_gt = 0; last_br = 0;
    for (int i = 0; i < 16; i++) begin
      rf[i] = 32'd100 + 32'(i); arch[i] = rf[i];
    end
    repeat (2) @(negedge clk);
    check("R1 reset", {we, br, 36'd0}, 38'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: flags clear, conditional ops suppressed before any compare
    issue("R1 gt before cmp", 1, 3'd3, 4'd4, 4'd5, 4'd1, 4'd2, 0);
    issue("R1 le before cmp", 1, 3'd3, 4'd5, 4'd5, 4'd1, 4'd2, 0);
    issue("R1 ne br before cmp", 1, 3'd4, 4'd2, 0, 4'd1, 4'd2, 0);
    // R6 shifted add, x16 and wrap at shift 31
    issue("R6 add shl4", 1, 3'd2, 4'd0, 4'd3, 4'd1, 4'd2, 5'd4);
    issue("R6 add shl31", 1, 3'd2, 4'd0, 4'd4, 4'd2, 4'd3, 5'd31);
    // R10 back-to-back dependency on r4
    issue("R10 bypass", 1, 3'd3, 4'd0, 4'd6, 4'd4, 4'd4, 0);
    issue("R10 bypass chain", 1, 3'd2, 4'd0, 4'd6, 4'd6, 4'd1, 5'd1);
    // R2 signed compare: negative vs positive, cond never ignored
    arch[7] = 32'h8000_0000; rf[7] = 32'h8000_0000;
    issue("R2 cmp neg", 1, 3'd1, 4'd9, 4'd7, 4'd7, 4'd1, 0);
    issue("R7 lt", 1, 3'd3, 4'd3, 4'd8, 4'd1, 4'd2, 0);
    issue("R3 gt suppressed", 1, 3'd3, 4'd4, 4'd9, 4'd1, 4'd2, 0);
    issue("R4 le exec", 1, 3'd3, 4'd5, 4'd9, 4'd1, 4'd2, 0);
    // R11 idle and R8 flags unchanged
    issue("R11 idle", 0, 3'd2, 4'd0, 4'd10, 4'd1, 4'd2, 0);
    issue("R8 flags held", 1, 3'd3, 4'd3, 4'd10, 4'd1, 4'd2, 0);
    issue("R7 never", 1, 3'd2, 4'd8, 4'd11, 4'd1, 4'd2, 0);
    issue("R2 cmp eq", 1, 3'd1, 4'd0, 0, 4'd1, 4'd1, 0);
    issue("R7 eq", 1, 3'd2, 4'd1, 4'd11, 4'd1, 4'd1, 0);
    issue("R7 ge", 1, 3'd3, 4'd6, 4'd12, 4'd1, 4'd2, 0);
    issue("R5 ne on eq", 1, 3'd4, 4'd2, 0, 0, 0, 0);
    // R3 R4 R5 R9: subtract-until-equal loop on r1=48, r2=18
    arch[1] = 32'd48; rf[1] = 32'd48; arch[2] = 32'd18; rf[2] = 32'd18;
    iter = 0;
    do begin
      issue("R2 loop cmp", 1, 3'd1, 4'd0, 0, 4'd1, 4'd2, 0);
      issue("R3 loop gt", 1, 3'd3, 4'd4, 4'd1, 4'd1, 4'd2, 0);
      issue("R4 loop le", 1, 3'd3, 4'd5, 4'd2, 4'd2, 4'd1, 0);
      issue("R5 loop br", 1, 3'd4, 4'd2, 0, 4'd1, 4'd2, 0);
      iter++;
    end while (last_br && iter < 20);
    @(negedge clk);
    check("R9 loop result", {6'd0, rf[1]}, {6'd0, 32'd6});
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] s, t;
      s = 4'($urandom_range(0, 15));
      t = ($urandom_range(0, 3) == 0) ? s : 4'($urandom_range(0, 15));
      issue("R9 random", ($urandom_range(0, 9) != 0), 3'($urandom_range(0, 4)),
            4'($urandom_range(0, 8)), 4'($urandom_range(0, 15)), s, t,
            5'($urandom_range(0, 31)));
    end
    op_valid = 0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) check("R10 regfile", {6'd0, rf[i]}, {6'd0, arch[i]});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule